// File: doc/BRIEF.md
# Decode-Stage RAW Hazard and Forwarding Unit

This block sits in the decode stage of an in-order five-stage pipeline. Every cycle it takes the two source register indices of the instruction being decoded and compares them with the destination indices of the three older instructions in execute, memory and writeback. Only stages that hold a valid instruction that writes a register take part. The block then decides, per operand, whether the value read from the register file can be used, whether the execute-stage result must be routed into the operand, or whether decode has to wait.

Only the execute stage has a bypass, and it reaches only the end of decode. A load's data appears only at writeback. Any operand that depends on a load still in execute, or on any instruction still in memory, therefore holds decode and fetch and sends a bubble into execute. A dependence on the writeback stage needs nothing, because the register file passes its own write through to its read ports in that cycle. A parameter instead makes such a dependence stall, for a register file without that pass-through. Write-after-write and write-after-read orderings never stall.

The outputs are combinational. The pipeline registers around the block use them at the same clock edge.

Top module: `raw_fwd_unit`

## Requirements
- R1: When neither used source index matches a qualifying older destination, both forward selects and both stall outputs are 0. This includes the state after reset, when every stage valid is 0.
- R2: When a valid, register-writing, non-load execute instruction has a destination equal to a used source index, that operand's forward select is 1 (execute result), and no stall is raised for it. A select of 0 means the register file value.
- R3: When a valid, register-writing load in execute has a destination equal to a used source index, stall_fd and bubble_ex are 1 and that operand's forward select is 0.
- R4: When a used source index matches a valid, register-writing memory-stage destination and no qualifying execute-stage match exists for it, stall_fd and bubble_ex are 1.
- R5: The youngest writer decides. A non-load execute match on an operand forwards without stalling, even when the memory stage writes the same register.
- R6: With WB_RF_BYPASS=1 (the default), a match only against the writeback stage gives forward select 0 and no stall.
- R7: Source index 0 never creates a dependence, whatever the stages write to register 0.
- R8: A stage whose valid is 0 or whose write flag is 0 takes no part in any comparison.
- R9: A source whose used flag is 0, or any source while dec_valid is 0, creates no dependence.
- R10: Each operand is resolved independently. stall_fd is 1 when either operand must wait, and bubble_ex always equals stall_fd.
- R11: An instruction that reads the destination of the load just ahead of it is held in decode for exactly two cycles. It issues in the cycle the load reaches writeback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dec_valid | input | 1 | Decode stage holds an instruction |
| dec_rs1 | input | REG_IDX_W | First source register index |
| dec_rs1_used | input | 1 | First source is actually read |
| dec_rs2 | input | REG_IDX_W | Second source register index |
| dec_rs2_used | input | 1 | Second source is actually read |
| ex_valid | input | 1 | Execute stage holds an instruction |
| ex_wr | input | 1 | Execute instruction writes a register |
| ex_load | input | 1 | Execute instruction is a load |
| ex_rd | input | REG_IDX_W | Execute destination index |
| mem_valid | input | 1 | Memory stage holds an instruction |
| mem_wr | input | 1 | Memory instruction writes a register |
| mem_rd | input | REG_IDX_W | Memory destination index |
| wb_valid | input | 1 | Writeback stage holds an instruction |
| wb_wr | input | 1 | Writeback instruction writes a register |
| wb_rd | input | REG_IDX_W | Writeback destination index |
| fwd_rs1_ex | output | 1 | 1: first operand takes the execute result |
| fwd_rs2_ex | output | 1 | 1: second operand takes the execute result |
| stall_fd | output | 1 | Hold fetch and decode this cycle |
| bubble_ex | output | 1 | Load a no-op into execute at the next edge |

## Verification
The block holds no state, so a wrong decision appears at the ports in the same cycle as the stage contents that cause it. The error shows either as a forward select pointing at the wrong source or as a stall that is missing or extra. Inside a running pipeline a missing stall lets a dependent instruction leave decode early. An extra stall shows up as a wrong count of held cycles, for example after a load followed by its consumer. The bench therefore runs both directed stage contents and an instruction stream advanced by a behavioural pipeline model. It compares every output on every clock, so a fault is reported at the first cycle it is visible.

// File: rtl/raw_pkg.sv
package raw_pkg;

  // Stage slots as seen from decode, youngest first.
  localparam int STG_EX     = 0;
  localparam int STG_MEM    = 1;
  localparam int STG_WB     = 2;
  localparam int NUM_STAGES = 3;

  // Where one operand gets its value this cycle.
  typedef enum logic [1:0] {
    SRC_RF   = 2'd0,
    SRC_EX   = 2'd1,
    SRC_WAIT = 2'd2
  } opnd_src_e;

endpackage

// File: rtl/raw_stage_cmp.sv
module raw_stage_cmp #(
  parameter int REG_IDX_W = 5
) (
  input  logic [REG_IDX_W-1:0] src_idx,
  input  logic                 src_used,
  input  logic                 st_valid,
  input  logic                 st_wr,
  input  logic [REG_IDX_W-1:0] st_rd,
  output logic                 hit
);

  localparam logic [REG_IDX_W-1:0] ZERO_IDX = '0;

  always_comb begin
    hit = src_used && st_valid && st_wr &&
          (st_rd != ZERO_IDX) && (st_rd == src_idx);
  end

  always_comb begin
    // R8
    if (!st_valid || !st_wr) idle_stage_chk: assert (!hit);
    // R9
    if (!src_used) unused_src_chk: assert (!hit);
  end

endmodule

// File: rtl/raw_operand_sel.sv
module raw_operand_sel
  import raw_pkg::*;
#(
  parameter int REG_IDX_W = 5,
  parameter bit WB_STALL  = 1'b0
) (
  input  logic [REG_IDX_W-1:0]  src_idx,
  input  logic                  src_used,
  input  logic [NUM_STAGES-1:0] st_valid,
  input  logic [NUM_STAGES-1:0] st_wr,
  input  logic [REG_IDX_W-1:0]  st_rd [NUM_STAGES],
  input  logic                  ex_load,
  output opnd_src_e             decision
);

  logic [NUM_STAGES-1:0] hit;

  for (genvar s = 0; s < NUM_STAGES; s++) begin : g_cmp
    raw_stage_cmp #(.REG_IDX_W(REG_IDX_W)) u_cmp (
      .src_idx (src_idx),
      .src_used(src_used),
      .st_valid(st_valid[s]),
      .st_wr   (st_wr[s]),
      .st_rd   (st_rd[s]),
      .hit     (hit[s])
    );
  end

  // Youngest writer wins; only execute has a bypass path.
  always_comb begin
    if (hit[STG_EX])                   decision = ex_load ? SRC_WAIT : SRC_EX;
    else if (hit[STG_MEM])             decision = SRC_WAIT;
    else if (hit[STG_WB] && WB_STALL)  decision = SRC_WAIT;
    else                               decision = SRC_RF;
  end

  localparam logic [REG_IDX_W-1:0] ZERO_IDX = '0;

  always_comb begin
    // R7
    if (src_idx == ZERO_IDX) zero_src_chk: assert (decision == SRC_RF);
    // R3
    if (decision == SRC_EX) ex_not_load_chk: assert (!ex_load && st_valid[STG_EX]);
    // R4
    if (decision == SRC_WAIT && !st_valid[STG_EX])
      mem_wait_chk: assert (st_valid[STG_MEM] || (WB_STALL && st_valid[STG_WB]));
  end

endmodule

// File: rtl/raw_fwd_unit.sv
module raw_fwd_unit
  import raw_pkg::*;
#(
  parameter int REG_IDX_W    = 5,
  parameter bit WB_RF_BYPASS = 1'b1
) (
  input  logic                 dec_valid,
  input  logic [REG_IDX_W-1:0] dec_rs1,
  input  logic                 dec_rs1_used,
  input  logic [REG_IDX_W-1:0] dec_rs2,
  input  logic                 dec_rs2_used,
  input  logic                 ex_valid,
  input  logic                 ex_wr,
  input  logic                 ex_load,
  input  logic [REG_IDX_W-1:0] ex_rd,
  input  logic                 mem_valid,
  input  logic                 mem_wr,
  input  logic [REG_IDX_W-1:0] mem_rd,
  input  logic                 wb_valid,
  input  logic                 wb_wr,
  input  logic [REG_IDX_W-1:0] wb_rd,
  output logic                 fwd_rs1_ex,
  output logic                 fwd_rs2_ex,
  output logic                 stall_fd,
  output logic                 bubble_ex
);

  localparam int NUM_SRC  = 2;
  localparam bit WB_STALL = !WB_RF_BYPASS;

  logic [NUM_STAGES-1:0] st_valid;
  logic [NUM_STAGES-1:0] st_wr;
  logic [REG_IDX_W-1:0]  st_rd   [NUM_STAGES];
  logic [REG_IDX_W-1:0]  src_idx [NUM_SRC];
  logic [NUM_SRC-1:0]    src_used;
  opnd_src_e             src_dec [NUM_SRC];
  logic                  wait_any;

  always_comb begin
    st_valid[STG_EX]  = ex_valid;
    st_valid[STG_MEM] = mem_valid;
    st_valid[STG_WB]  = wb_valid;
    st_wr[STG_EX]     = ex_wr;
    st_wr[STG_MEM]    = mem_wr;
    st_wr[STG_WB]     = wb_wr;
    st_rd[STG_EX]     = ex_rd;
    st_rd[STG_MEM]    = mem_rd;
    st_rd[STG_WB]     = wb_rd;
    src_idx[0]        = dec_rs1;
    src_idx[1]        = dec_rs2;
    src_used[0]       = dec_valid && dec_rs1_used;
    src_used[1]       = dec_valid && dec_rs2_used;
  end

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    raw_operand_sel #(
      .REG_IDX_W(REG_IDX_W),
      .WB_STALL (WB_STALL)
    ) u_sel (
      .src_idx (src_idx[g]),
      .src_used(src_used[g]),
      .st_valid(st_valid),
      .st_wr   (st_wr),
      .st_rd   (st_rd),
      .ex_load (ex_load),
      .decision(src_dec[g])
    );
  end

  always_comb begin
    wait_any = 1'b0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (src_dec[i] == SRC_WAIT) wait_any = 1'b1;
    end
  end

  assign fwd_rs1_ex = (src_dec[0] == SRC_EX);
  assign fwd_rs2_ex = (src_dec[1] == SRC_EX);
  assign stall_fd   = wait_any;
  assign bubble_ex  = wait_any;

  always_comb begin
    // R3
    if (dec_valid && dec_rs1_used && ex_valid && ex_wr && ex_load &&
        ex_rd == dec_rs1 && dec_rs1 != '0)
      ex_load_stall_chk: assert (stall_fd && !fwd_rs1_ex);
    // R6
    if (WB_RF_BYPASS && !ex_valid && !mem_valid)
      wb_no_stall_chk: assert (!stall_fd);
    // R9
    if (!dec_valid)
      dec_idle_chk: assert (!stall_fd && !fwd_rs1_ex && !fwd_rs2_ex);
    // R10
    bubble_match_chk: assert (bubble_ex == stall_fd);
  end

endmodule

// File: tb/raw_fwd_unit_tb.sv
module raw_fwd_unit_tb;

  localparam int CLK_PERIOD = 10;
  localparam int IW = 5;
  localparam int NPROG = 10;

  logic clk = 1'b0;
  logic rst;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic          dec_valid, dec_rs1_used, dec_rs2_used;
  logic [IW-1:0] dec_rs1, dec_rs2;
  logic          ex_valid, ex_wr, ex_load, mem_valid, mem_wr, wb_valid, wb_wr;
  logic [IW-1:0] ex_rd, mem_rd, wb_rd;
  logic          fwd_rs1_ex, fwd_rs2_ex, stall_fd, bubble_ex;

  raw_fwd_unit #(.REG_IDX_W(IW)) u_dut (
    .dec_valid(dec_valid), .dec_rs1(dec_rs1), .dec_rs1_used(dec_rs1_used),
    .dec_rs2(dec_rs2), .dec_rs2_used(dec_rs2_used),
    .ex_valid(ex_valid), .ex_wr(ex_wr), .ex_load(ex_load), .ex_rd(ex_rd),
    .mem_valid(mem_valid), .mem_wr(mem_wr), .mem_rd(mem_rd),
    .wb_valid(wb_valid), .wb_wr(wb_wr), .wb_rd(wb_rd),
    .fwd_rs1_ex(fwd_rs1_ex), .fwd_rs2_ex(fwd_rs2_ex),
    .stall_fd(stall_fd), .bubble_ex(bubble_ex)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  // program: sources, use flags, destination, writes, is-load
  int p_rs1 [NPROG];
  int p_rs2 [NPROG];
  int p_u1  [NPROG];
  int p_u2  [NPROG];
  int p_rd  [NPROG];
  int p_wr  [NPROG];
  int p_ld  [NPROG];

  task automatic set_inst(int i, int r1, int u1, int r2, int u2, int rd, int wr, int ld);
    p_rs1[i] = r1; p_u1[i] = u1; p_rs2[i] = r2; p_u2[i] = u2;
    p_rd[i] = rd; p_wr[i] = wr; p_ld[i] = ld;
  endtask

  // Behavioural reference: 0 register file, 1 execute result, 2 wait
  function automatic int ref_src(logic [IW-1:0] src, logic used);
    if (!dec_valid || !used || src == 0) return 0;
    if (ex_valid && ex_wr && ex_rd == src) return ex_load ? 2 : 1;
    if (mem_valid && mem_wr && mem_rd == src) return 2;
    return 0;
  endfunction

  task automatic chk1(logic act, logic exp, string tag, string what);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
    end
  endtask

  task automatic chk(logic ef1, logic ef2, logic est, string tag);
    chk1(fwd_rs1_ex, ef1, tag, "fwd_rs1_ex");
    chk1(fwd_rs2_ex, ef2, tag, "fwd_rs2_ex");
    chk1(stall_fd,   est, tag, "stall_fd");
    chk1(bubble_ex,  est, tag, "bubble_ex");
  endtask

  task automatic chk_model(string tag);
    int c1, c2;
    c1 = ref_src(dec_rs1, dec_rs1_used);
    c2 = ref_src(dec_rs2, dec_rs2_used);
    chk(c1 == 1, c2 == 1, (c1 == 2) || (c2 == 2), tag);
  endtask

  task automatic clear_all();
    dec_valid = 0; dec_rs1 = 0; dec_rs1_used = 0; dec_rs2 = 0; dec_rs2_used = 0;
    ex_valid = 0; ex_wr = 0; ex_load = 0; ex_rd = 0;
    mem_valid = 0; mem_wr = 0; mem_rd = 0;
    wb_valid = 0; wb_wr = 0; wb_rd = 0;
  endtask

  task automatic set_dec(int r1, int u1, int r2, int u2);
    dec_valid = 1; dec_rs1 = IW'(r1); dec_rs1_used = u1[0];
    dec_rs2 = IW'(r2); dec_rs2_used = u2[0];
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  // watchdog
  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    // pipeline model state (bench-side), slot 0 EX, 1 MEM, 2 WB
    int s_v [3]; int s_w [3]; int s_l [3]; int s_rd [3];
    int pc, ld_hold, exp_c;

    rst = 1'b1;
    clear_all();
    repeat (2) @(posedge clk);
    rst = 1'b0;
    step();
    // R1 reset state: everything invalid
    chk(0, 0, 0, "R1");

    // R1 valid writers on unrelated registers
    set_dec(1, 1, 2, 1);
    ex_valid = 1; ex_wr = 1; ex_rd = 3;
    mem_valid = 1; mem_wr = 1; mem_rd = 4;
    wb_valid = 1; wb_wr = 1; wb_rd = 5;
    #1 chk(0, 0, 0, "R1");

    // R2 execute forward, one then both operands
    step(); clear_all(); set_dec(3, 1, 2, 1);
    ex_valid = 1; ex_wr = 1; ex_rd = 3;
    #1 chk(1, 0, 0, "R2");
    dec_rs2 = 3;
    #1 chk(1, 1, 0, "R2");

    // R3 load in execute
    step(); clear_all(); set_dec(1, 1, 4, 1);
    ex_valid = 1; ex_wr = 1; ex_load = 1; ex_rd = 4;
    #1 chk(0, 0, 1, "R3");

    // R4 memory-stage writer
    step(); clear_all(); set_dec(7, 1, 1, 1);
    mem_valid = 1; mem_wr = 1; mem_rd = 7;
    #1 chk(0, 0, 1, "R4");

    // R5 execute shadows memory on the same register
    ex_valid = 1; ex_wr = 1; ex_rd = 7;
    #1 chk(1, 0, 0, "R5");

    // R6 writeback-only match
    step(); clear_all(); set_dec(9, 1, 9, 1);
    wb_valid = 1; wb_wr = 1; wb_rd = 9;
    #1 chk(0, 0, 0, "R6");

    // R7 register zero
    step(); clear_all(); set_dec(0, 1, 0, 1);
    ex_valid = 1; ex_wr = 1; ex_rd = 0;
    #1 chk(0, 0, 0, "R7");
    ex_valid = 0; mem_valid = 1; mem_wr = 1; mem_rd = 0;
    #1 chk(0, 0, 0, "R7");

    // R8 invalid or non-writing stages ignored
    step(); clear_all(); set_dec(6, 1, 6, 1);
    ex_valid = 0; ex_wr = 1; ex_rd = 6;
    mem_valid = 1; mem_wr = 0; mem_rd = 6;
    #1 chk(0, 0, 0, "R8");
    ex_valid = 1; ex_wr = 0;
    #1 chk(0, 0, 0, "R8");

    // R9 unused source and idle decode
    step(); clear_all(); set_dec(5, 0, 2, 1);
    ex_valid = 1; ex_wr = 1; ex_load = 1; ex_rd = 5;
    #1 chk(0, 0, 0, "R9");
    dec_valid = 0; dec_rs1_used = 1;
    mem_valid = 1; mem_wr = 1; mem_rd = 2;
    #1 chk(0, 0, 0, "R9");

    // R10 one operand forwards, the other waits
    step(); clear_all(); set_dec(3, 1, 8, 1);
    ex_valid = 1; ex_wr = 1; ex_rd = 3;
    mem_valid = 1; mem_wr = 1; mem_rd = 8;
    #1 chk(1, 0, 1, "R10");

    // R11 instruction stream through a behavioural pipeline model
    set_inst(0, 1, 1, 0, 0, 5, 1, 1); // load x5
    set_inst(1, 5, 1, 2, 1, 6, 1, 0); // uses x5 -> two held cycles
    set_inst(2, 6, 1, 6, 1, 7, 1, 0); // execute forward
    set_inst(3, 1, 1, 2, 1, 8, 1, 0);
    set_inst(4, 6, 1, 7, 1, 9, 1, 0); // x7 in memory -> wait
    set_inst(5, 9, 1, 9, 1, 0, 1, 0); // writes x0
    set_inst(6, 0, 1, 0, 1, 10, 1, 0);
    set_inst(7, 10, 1, 9, 1, 0, 0, 0); // store, no write
    set_inst(8, 10, 1, 3, 1, 11, 1, 1);
    set_inst(9, 11, 1, 11, 1, 12, 1, 0);
    for (int s = 0; s < 3; s++) begin s_v[s] = 0; s_w[s] = 0; s_l[s] = 0; s_rd[s] = 0; end
    pc = 0; ld_hold = 0;
    for (int cyc = 0; cyc < 40; cyc++) begin
      step();
      dec_valid = (pc < NPROG);
      if (pc < NPROG) begin
        dec_rs1 = IW'(p_rs1[pc]); dec_rs1_used = p_u1[pc][0];
        dec_rs2 = IW'(p_rs2[pc]); dec_rs2_used = p_u2[pc][0];
      end
      ex_valid = s_v[0][0];  ex_wr = s_w[0][0];  ex_load = s_l[0][0]; ex_rd = IW'(s_rd[0]);
      mem_valid = s_v[1][0]; mem_wr = s_w[1][0]; mem_rd = IW'(s_rd[1]);
      wb_valid = s_v[2][0];  wb_wr = s_w[2][0];  wb_rd = IW'(s_rd[2]);
      #1;
      exp_c = ((ref_src(dec_rs1, dec_rs1_used) == 2) ||
               (ref_src(dec_rs2, dec_rs2_used) == 2)) ? 1 : 0;
      chk_model("R11");
      if (pc == 1 && exp_c == 1) ld_hold++;
      @(posedge clk);
      for (int s = 2; s > 0; s--) begin
        s_v[s] = s_v[s-1]; s_w[s] = s_w[s-1]; s_l[s] = s_l[s-1]; s_rd[s] = s_rd[s-1];
      end
      if (exp_c == 1 || pc >= NPROG) begin
        s_v[0] = 0; s_w[0] = 0; s_l[0] = 0; s_rd[0] = 0;
      end else begin
        s_v[0] = 1; s_w[0] = p_wr[pc]; s_l[0] = p_ld[pc]; s_rd[0] = p_rd[pc];
        pc++;
      end
    end
    n_checks++;
    if (ld_hold != 2) begin
      n_fail++;
      $display("FAIL R11 load-use hold cycles: actual %0d expected 2", ld_hold);
    end
    n_checks++;
    if (pc != NPROG) begin
      n_fail++;
      $display("FAIL R11 stream issue count: actual %0d expected %0d", pc, NPROG);
    end

    // R10 random stage contents on a small register range
    for (int k = 0; k < 400; k++) begin
      step();
      dec_valid = 1'($urandom_range(0, 7) != 0);
      dec_rs1 = IW'($urandom_range(0, 3)); dec_rs1_used = 1'($urandom_range(0, 1));
      dec_rs2 = IW'($urandom_range(0, 3)); dec_rs2_used = 1'($urandom_range(0, 1));
      ex_valid = 1'($urandom_range(0, 1)); ex_wr = 1'($urandom_range(0, 1));
      ex_load = 1'($urandom_range(0, 1)); ex_rd = IW'($urandom_range(0, 3));
      mem_valid = 1'($urandom_range(0, 1)); mem_wr = 1'($urandom_range(0, 1));
      mem_rd = IW'($urandom_range(0, 3));
      wb_valid = 1'($urandom_range(0, 1)); wb_wr = 1'($urandom_range(0, 1));
      wb_rd = IW'($urandom_range(0, 3));
      #1 chk_model("R10");
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule